// File: doc/BRIEF.md
# Accumulator ALU Micro-Engine

This block runs short bursts of packed 32-bit ALU micro-instructions against a file of sixteen 64-bit general registers. Each word carries an opcode in bits 31:20, a first operand code in bits 19:10 and a second operand code in bits 9:0. Three kinds of hidden state sit beside the register file. Two operand latches, A and B, feed the arithmetic. An accumulator takes each result. A zero flag and a carry flag describe the last result. Load words fill a latch. Arithmetic and logic words combine A with B into the accumulator. Store words copy the accumulator or a flag into a general register.

Words arrive on a valid/ready stream. Each word is executed in the clock cycle in which it is accepted. A burst length is presented alongside the first word of each burst. A one-cycle done pulse marks the end of every burst. A side port gives an external agent a direct path to the general registers. Reads on this port are combinational, and writes take effect at the clock edge. The agent uses the port to seed operands before a burst and to collect results after it.

Top module: `acc_alu_engine`

## Requirements
- R1: Operand code values 0x000 to 0x00F name R0 to R15. Code 0x020 names latch A, 0x021 latch B, 0x031 the accumulator, 0x032 the zero flag and 0x033 the carry flag. LOAD (0x080) copies the source named by the second operand into the latch named by the first operand. LOADINV (0x480) copies the bitwise inverse of that source.
- R2: LOAD0 (0x081) writes all zeros into the named latch, and LOAD1 (0x481) writes all ones. The second operand is ignored.
- R3: ADD (0x100) writes A+B modulo 2^64 into the accumulator. It sets the carry flag to the carry out of bit 63, and it sets the zero flag when the result is zero.
- R4: SUB (0x101) writes A−B modulo 2^64 into the accumulator. It sets the carry flag when B is greater than A (borrow), and it sets the zero flag when the result is zero.
- R5: AND (0x102), OR (0x103) and XOR (0x104) write the bitwise result of A and B into the accumulator. They clear the carry flag and set the zero flag when the result is zero.
- R6: STORE (0x180) writes the accumulator, zero flag or carry flag named by the second operand into the general register named by the first operand. STOREINV (0x580) writes the inverse. A flag is stored as all ones when set and all zeros when clear.
- R7: A word that has an undefined opcode, or an operand code not allowed for its opcode, changes no register, latch, accumulator or flag. Such a word still counts toward the burst length. Code 0x010 in particular does not alias to R0.
- R8: The burst length (1 to 64) is sampled with the first word of a burst. A value of 0 or above 64 is taken as 64. burst_done is high for exactly the one cycle after the edge that accepts the final word, and at no other time.
- R9: side_rdata shows register side_addr combinationally. When side_we is high, side_wdata is written at the clock edge, instr_ready is low and no word is accepted in that cycle.
- R10: After reset, all general registers, latches, the accumulator and both flags are zero, burst_done is low and instr_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Engine accepts a word this cycle |
| instr_word | input | 32 | Opcode, first operand, second operand |
| burst_len | input | 7 | Number of words in the burst, sampled on the first word |
| burst_done | output | 1 | One-cycle pulse after the final word of a burst |
| side_we | input | 1 | Side port write enable |
| side_addr | input | 4 | Side port register index |
| side_wdata | input | 64 | Side port write data |
| side_rdata | output | 64 | Side port read data |

## Verification
A table of operand pairs targets carry out of the top bit, borrow when B exceeds A, equal operands that give zero under SUB and XOR, and mixed logic patterns. A design with a wrong borrow sense or a stale zero flag would store the wrong flag word into R3 or R4. A burst of malformed words (an unknown operand code, an unknown opcode, a store to code 0x010 and a load aimed at a general register) must leave latch A and R0 untouched. A decoder that truncates operand codes would corrupt R0 or A. A side write presented alongside an instruction must block that instruction, and 64-word and 1-word bursts must each raise the done pulse exactly once on their final word. An off-by-one in the burst counter would pulse early or never.

// File: rtl/acc_alu_engine.sv
module acc_alu_engine #(
  parameter int DATA_W    = 64,
  parameter int NUM_REGS  = 16,
  parameter int MAX_BURST = 64,
  localparam int AW = $clog2(NUM_REGS),
  localparam int LW = $clog2(MAX_BURST) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr_word,
  input  logic [LW-1:0]     burst_len,
  output logic              burst_done,
  input  logic              side_we,
  input  logic [AW-1:0]     side_addr,
  input  logic [DATA_W-1:0] side_wdata,
  output logic [DATA_W-1:0] side_rdata
);

  localparam logic [11:0] OP_NOOP  = 12'h000;
  localparam logic [11:0] OP_LD    = 12'h080;
  localparam logic [11:0] OP_LDINV = 12'h480;
  localparam logic [11:0] OP_LD0   = 12'h081;
  localparam logic [11:0] OP_LD1   = 12'h481;
  localparam logic [11:0] OP_ADD   = 12'h100;
  localparam logic [11:0] OP_SUB   = 12'h101;
  localparam logic [11:0] OP_AND   = 12'h102;
  localparam logic [11:0] OP_OR    = 12'h103;
  localparam logic [11:0] OP_XOR   = 12'h104;
  localparam logic [11:0] OP_ST    = 12'h180;
  localparam logic [11:0] OP_STINV = 12'h580;

  localparam logic [9:0] C_LA   = 10'h020;
  localparam logic [9:0] C_LB   = 10'h021;
  localparam logic [9:0] C_ACC  = 10'h031;
  localparam logic [9:0] C_ZF   = 10'h032;
  localparam logic [9:0] C_CF   = 10'h033;
  localparam logic [9:0] C_NREG = 10'(NUM_REGS);
  localparam logic [LW-1:0] L_MAX = LW'(MAX_BURST);
  localparam logic [LW-1:0] L_ONE = LW'(1);

  logic [DATA_W-1:0] gpr [NUM_REGS];
  logic [DATA_W-1:0] lat_a, lat_b, acc_q;
  logic              zf_q, cf_q;
  logic [LW-1:0]     remain;

  wire [11:0] opc = instr_word[31:20];
  wire [9:0]  op1 = instr_word[19:10];
  wire [9:0]  op2 = instr_word[9:0];

  assign instr_ready = !side_we;
  assign side_rdata  = gpr[side_addr];
  wire accept = instr_valid && instr_ready;

  wire op1_latch = (op1 == C_LA) || (op1 == C_LB);
  wire op1_gpr   = op1 < C_NREG;
  wire op2_flagacc = (op2 == C_ACC) || (op2 == C_ZF) || (op2 == C_CF);
  wire op2_ok    = (op2 < C_NREG) || (op2 == C_LA) || (op2 == C_LB) || op2_flagacc;

  logic [DATA_W-1:0] src_val;
  always_comb begin
    case (op2)
      C_LA:    src_val = lat_a;
      C_LB:    src_val = lat_b;
      C_ACC:   src_val = acc_q;
      C_ZF:    src_val = {DATA_W{zf_q}};
      C_CF:    src_val = {DATA_W{cf_q}};
      default: src_val = (op2 < C_NREG) ? gpr[op2[AW-1:0]] : '0;
    endcase
  end

  wire [DATA_W:0] sum  = {1'b0, lat_a} + {1'b0, lat_b};
  wire [DATA_W:0] diff = {1'b0, lat_a} - {1'b0, lat_b};

  logic              do_load, do_alu, do_store;
  logic [DATA_W-1:0] load_val, store_val, alu_res;
  logic              alu_c;

  always_comb begin
    do_load   = 1'b0;
    do_alu    = 1'b0;
    do_store  = 1'b0;
    load_val  = src_val;
    store_val = src_val;
    alu_res   = '0;
    alu_c     = 1'b0;
    case (opc)
      OP_LD:    do_load = op1_latch && op2_ok;
      OP_LDINV: begin do_load = op1_latch && op2_ok; load_val = ~src_val; end
      OP_LD0:   begin do_load = op1_latch; load_val = '0; end
      OP_LD1:   begin do_load = op1_latch; load_val = '1; end
      OP_ADD:   begin do_alu = 1'b1; alu_res = sum[DATA_W-1:0];  alu_c = sum[DATA_W];  end
      OP_SUB:   begin do_alu = 1'b1; alu_res = diff[DATA_W-1:0]; alu_c = diff[DATA_W]; end
      OP_AND:   begin do_alu = 1'b1; alu_res = lat_a & lat_b; end
      OP_OR:    begin do_alu = 1'b1; alu_res = lat_a | lat_b; end
      OP_XOR:   begin do_alu = 1'b1; alu_res = lat_a ^ lat_b; end
      OP_ST:    do_store = op1_gpr && op2_flagacc;
      OP_STINV: begin do_store = op1_gpr && op2_flagacc; store_val = ~src_val; end
      OP_NOOP:  ;
      default:  ;
    endcase
  end

  wire [LW-1:0] len_eff = (burst_len == '0 || burst_len > L_MAX) ? L_MAX : burst_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) gpr[i] <= '0;
      lat_a      <= '0;
      lat_b      <= '0;
      acc_q      <= '0;
      zf_q       <= 1'b0;
      cf_q       <= 1'b0;
      remain     <= '0;
      burst_done <= 1'b0;
    end else begin
      burst_done <= 1'b0;
      if (side_we) gpr[side_addr] <= side_wdata;
      if (accept) begin
        if (do_load) begin
          if (op1 == C_LA) lat_a <= load_val;
          else             lat_b <= load_val;
        end
        if (do_alu) begin
          acc_q <= alu_res;
          zf_q  <= (alu_res == '0);
          cf_q  <= alu_c;
        end
        if (do_store) gpr[op1[AW-1:0]] <= store_val;
        if (remain == '0) begin
          remain     <= len_eff - L_ONE;
          burst_done <= (len_eff == L_ONE);
        end else begin
          remain     <= remain - L_ONE;
          burst_done <= (remain == L_ONE);
        end
      end
    end
  end

endmodule

// File: rtl/acc_alu_engine_chk.sv
module acc_alu_engine_chk #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 16,
  parameter int AW       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [31:0]       instr_word,
  input logic              burst_done,
  input logic              side_we,
  input logic [AW-1:0]     side_addr,
  input logic [DATA_W-1:0] side_wdata,
  input logic [DATA_W-1:0] side_rdata,
  input logic [DATA_W-1:0] acc,
  input logic              zf,
  input logic              cf,
  input logic [DATA_W-1:0] lat_a
);

  wire        acc_ok = instr_valid && instr_ready;
  wire [11:0] opc    = instr_word[31:20];
  wire        is_logic = (opc == 12'h102) || (opc == 12'h103) || (opc == 12'h104);
  wire        is_arith = (opc == 12'h100) || (opc == 12'h101) || is_logic;
  wire        st_zf  = (opc == 12'h180) && (instr_word[9:0] == 10'h032) &&
                       (instr_word[19:10] < 10'(NUM_REGS));

  a_r9_side_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    side_we |-> !instr_ready);

  a_r9_side_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(side_we) && side_addr == $past(side_addr)) |-> side_rdata == $past(side_wdata));

  a_r8_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(acc_ok));

  a_r5_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_ok && is_logic) |-> !cf);

  a_r3_zero_tracks_acc: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_ok && is_arith) |-> zf == (acc == '0));

  a_r6_flag_word: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_ok && st_zf) && side_addr == $past(instr_word[10 +: AW])) |->
      (side_rdata == '0 || side_rdata == '1));

  a_r7_noop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_ok && opc == 12'h000) |->
      (acc == $past(acc) && zf == $past(zf) && cf == $past(cf) && lat_a == $past(lat_a)));

endmodule

bind acc_alu_engine acc_alu_engine_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .instr_word(instr_word), .burst_done(burst_done), .side_we(side_we),
  .side_addr(side_addr), .side_wdata(side_wdata), .side_rdata(side_rdata),
  .acc(acc_q), .zf(zf_q), .cf(cf_q), .lat_a(lat_a)
);

// File: tb/test_acc_alu_engine.sv
`timescale 1ns/1ps
module test_acc_alu_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic [6:0]  burst_len = '0;
  logic        burst_done;
  logic        side_we = 1'b0;
  logic [3:0]  side_addr = '0;
  logic [63:0] side_wdata = '0;
  logic [63:0] side_rdata;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  acc_alu_engine i_acc_alu_engine (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .burst_len(burst_len), .burst_done(burst_done),
    .side_we(side_we), .side_addr(side_addr), .side_wdata(side_wdata),
    .side_rdata(side_rdata)
  );

  localparam int NV = 9;
  localparam logic [11:0] V_OP [0:NV-1] = '{12'h100, 12'h100, 12'h101, 12'h101, 12'h102,
                                            12'h103, 12'h104, 12'h101, 12'h100};
  localparam logic [63:0] V_A [0:NV-1] = '{64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd5,
    64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0F0F_0F0F_0F0F, 64'h1234, 64'h10, 64'h8000_0000_0000_0000};
  localparam logic [63:0] V_B [0:NV-1] = '{64'd2, 64'd1, 64'd2, 64'd5,
    64'hFF00_FF00_FF00_FF00, 64'hF0F0_F0F0_F0F0_F0F0, 64'h1234, 64'h3, 64'h8000_0000_0000_0000};
  localparam logic [63:0] V_R [0:NV-1] = '{64'd3, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0,
    64'hF000_F000_F000_F000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'hD, 64'd0};
  localparam logic V_C [0:NV-1] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic V_Z [0:NV-1] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic [31:0] prog [0:63];

  function automatic logic [31:0] mk(input logic [11:0] o, input logic [9:0] a, input logic [9:0] b);
    return {o, a, b};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    side_we = 1'b1; side_addr = a; side_wdata = d;
    @(negedge clk);
    side_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    side_addr = a;
    #0.5;
    d = side_rdata;
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic [6:0] len, output int dones, output logic last);
    dones = 0; last = 1'b0;
    for (int i = 0; i < n; i++) begin
      instr_valid = 1'b1; instr_word = prog[i]; burst_len = len;
      @(negedge clk);
      instr_valid = 1'b0;
      if (burst_done) dones++;
      last = burst_done;
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    int          d;
    logic        l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 done low", {63'd0, burst_done}, 64'd0);
    check("R10 ready high", {63'd0, instr_ready}, 64'd1);
    for (int r = 0; r < 16; r++) begin
      rd(4'(r), v);
      check("R10 gpr zero", v, 64'd0);
    end

    // R3 R4 R5 R6 R8 vector table
    for (int i = 0; i < NV; i++) begin
      wr(4'd0, V_A[i]);
      wr(4'd1, V_B[i]);
      prog[0] = mk(12'h080, 10'h020, 10'h000);
      prog[1] = mk(12'h080, 10'h021, 10'h001);
      prog[2] = mk(V_OP[i], 10'h000, 10'h000);
      prog[3] = mk(12'h180, 10'h002, 10'h031);
      prog[4] = mk(12'h180, 10'h003, 10'h033);
      prog[5] = mk(12'h180, 10'h004, 10'h032);
      run(6, 7'd6, d, l);
      check("R8 one done on last word", {63'd0, (d == 1) && l}, 64'd1);
      rd(4'd2, v); check("R3/R4/R5 accumulator", v, V_R[i]);
      rd(4'd3, v); check("R6 carry word", v, {64{V_C[i]}});
      rd(4'd4, v); check("R6 zero word", v, {64{V_Z[i]}});
    end

    // R1 R2 R6 inverted and constant forms
    wr(4'd0, 64'h00FF_0000_1234_5678);
    prog[0] = mk(12'h480, 10'h020, 10'h000);
    prog[1] = mk(12'h081, 10'h021, 10'h3FF);
    prog[2] = mk(12'h103, 10'h000, 10'h000);
    prog[3] = mk(12'h180, 10'h005, 10'h031);
    prog[4] = mk(12'h481, 10'h020, 10'h000);
    prog[5] = mk(12'h100, 10'h000, 10'h000);
    prog[6] = mk(12'h580, 10'h006, 10'h031);
    prog[7] = mk(12'h580, 10'h007, 10'h032);
    run(8, 7'd8, d, l);
    check("R8 done after 8", {63'd0, (d == 1) && l}, 64'd1);
    rd(4'd5, v); check("R1 loadinv", v, 64'hFF00_FFFF_EDCB_A987);
    rd(4'd6, v); check("R2 load1 storeinv acc", v, 64'd0);
    rd(4'd7, v); check("R6 storeinv zero flag", v, 64'hFFFF_FFFF_FFFF_FFFF);

    // R7 malformed words leave state alone (acc is all ones here)
    wr(4'd0, 64'd5);
    wr(4'd1, 64'd0);
    prog[0] = mk(12'h080, 10'h020, 10'h000);
    prog[1] = mk(12'h080, 10'h021, 10'h001);
    prog[2] = mk(12'h080, 10'h020, 10'h025);
    prog[3] = mk(12'h7FF, 10'h002, 10'h000);
    prog[4] = mk(12'h180, 10'h010, 10'h031);
    prog[5] = mk(12'h080, 10'h003, 10'h001);
    prog[6] = mk(12'h103, 10'h000, 10'h000);
    prog[7] = mk(12'h180, 10'h009, 10'h031);
    run(8, 7'd8, d, l);
    check("R7 malformed words still counted", {63'd0, (d == 1) && l}, 64'd1);
    rd(4'd9, v); check("R7 latch A untouched", v, 64'd5);
    rd(4'd0, v); check("R7 code 0x010 not R0", v, 64'd5);

    // R9 side write blocks instruction
    side_we = 1'b1; side_addr = 4'd10; side_wdata = 64'hA5A5_0000_0000_5A5A;
    instr_valid = 1'b1; instr_word = mk(12'h180, 10'h00A, 10'h031); burst_len = 7'd1;
    #0.5;
    check("R9 ready low on side write", {63'd0, instr_ready}, 64'd0);
    @(negedge clk);
    side_we = 1'b0; instr_valid = 1'b0;
    check("R9 no done when blocked", {63'd0, burst_done}, 64'd0);
    rd(4'd10, v); check("R9 side write wins", v, 64'hA5A5_0000_0000_5A5A);

    // R8 single and maximum bursts
    prog[0] = mk(12'h000, 10'h000, 10'h000);
    run(1, 7'd1, d, l);
    check("R8 length one", {63'd0, (d == 1) && l}, 64'd1);
    for (int i = 0; i < 64; i++) prog[i] = mk(12'h000, 10'h000, 10'h000);
    run(64, 7'd64, d, l);
    check("R8 length 64", {63'd0, (d == 1) && l}, 64'd1);
    run(64, 7'd0, d, l);
    check("R8 length 0 as 64", {63'd0, (d == 1) && l}, 64'd1);
    @(negedge clk);
    check("R8 pulse one cycle", {63'd0, burst_done}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule